// File: doc/BRIEF.md
# Scrolling Frame Buffer Address Generator

This block produces the stream of halfword fetch addresses that a display refresh engine uses to read a frame buffer. The visible picture is a window into a wider virtual screen in memory. Each displayed line fetches a fixed number of halfwords. After the last halfword of a line the pointer jumps over a programmable gap, so software can scroll the viewport sideways by moving the start address and nothing else.

A frame-start pulse captures the configuration and points the generator at the first halfword. Each pixel request then moves the pointer on by one position. Two flags mark the last halfword of a line and the completion of the frame. The 32-bit words returned from memory pass through an optional lane swap. That swap can exchange the bytes inside each halfword, the two halfwords of each word, or both, so that either memory byte order can feed the pixel path.

Top module: `fb_addr_gen`

## Requirements
- R1: After reset `fetch_addr` is zero and both `line_end` and `frame_end` are low.
- R2: A cycle with `frame_start` high loads `fetch_addr` with `{cfg_bank, cfg_base}` and clears `frame_end`. A request in the same cycle is ignored. All `cfg_*` inputs except the two swap controls are sampled only in that cycle, and changing them later has no effect on the running frame.
- R3: While a frame is running, each request that is not the last of its line adds one to the base field of `fetch_addr`. A request made when no frame is running leaves `fetch_addr` and both flags unchanged.
- R4: The request that fetches the last halfword of a line (the `cfg_page_width`-th request of that line) adds `cfg_offset + 1` to the base field.
- R5: `line_end` is high exactly while a frame is running and `fetch_addr` holds the last halfword of a line.
- R6: After the last request of line number `cfg_line_last + 1`, `frame_end` goes high and stays high until the next frame start. At that point the base field equals `cfg_base + (cfg_page_width + cfg_offset) * (cfg_line_last + 1)` modulo 2^21. Any further requests are ignored.
- R7: The bank field (`fetch_addr[27:21]`) keeps its loaded value for the whole frame. The base field (`fetch_addr[20:0]`) wraps modulo 2^21 and never carries into the bank field.
- R8: A frame started with `cfg_page_width` equal to zero never runs. Requests are ignored, the address stays at the loaded value, and both flags stay low.
- R9: With `swap_bytes` high and `swap_halves` low, `rd_data_out` carries the two bytes of each halfword of `rd_data_in` exchanged: out[7:0]=in[15:8], out[15:8]=in[7:0], out[23:16]=in[31:24], out[31:24]=in[23:16].
- R10: With `swap_halves` high, `rd_data_out[15:0]` and `[31:16]` take `rd_data_in[31:16]` and `[15:0]` respectively. With both swap controls high, all four bytes come out in reverse order. With neither high, the data passes through unchanged. The swap is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bank | input | 7 | Upper address field, fixed for a frame |
| cfg_base | input | 21 | Start halfword address within the bank |
| cfg_page_width | input | 11 | Halfwords fetched per displayed line |
| cfg_offset | input | 11 | Halfwords skipped between lines |
| cfg_line_last | input | 10 | Number of displayed lines minus one |
| swap_bytes | input | 1 | Exchange the bytes inside each halfword of read data |
| swap_halves | input | 1 | Exchange the halfwords of each word of read data |
| frame_start | input | 1 | Capture configuration and restart at the base |
| pix_req | input | 1 | Advance to the next halfword |
| fetch_addr | output | 28 | Current halfword address {bank, base} |
| line_end | output | 1 | Current address is the last of its line |
| frame_end | output | 1 | Frame finished, pointer at the end address |
| rd_data_in | input | 32 | Word returned from memory |
| rd_data_out | output | 32 | Word after optional lane swap |

## Verification
The hardest condition to reach from the ports is a frame whose base field wraps past 2^21 in the middle of a line or a skip. In that case the bank field must not change, and the wrapped end address must still satisfy the closed-form formula. The stimulus reaches it with a directed frame whose base sits a few halfwords below the wrap point, using a large gap. Randomised frames add short page widths and random request gaps, and they change the configuration inputs while a frame is running. This exercises line boundaries, the one-halfword page, the zero gap and the latching of the configuration many times in a short run.

// File: rtl/fb_pkg.sv
package fb_pkg;
   // Field widths of the halfword address and of the geometry controls.
   localparam int BANK_W   = 7;
   localparam int BASE_W   = 21;
   localparam int PAGE_W   = 11;
   localparam int GAP_W    = 11;
   localparam int LINES_W  = 10;
   localparam int WORD_W   = 32;

   typedef struct packed {
      logic [BANK_W-1:0]  bank;
      logic [BASE_W-1:0]  base;
      logic [PAGE_W-1:0]  page;
      logic [GAP_W-1:0]   gap;
      logic [LINES_W-1:0] lines;
   } fb_geom_t;
endpackage

// File: rtl/fb_end_calc.sv
module fb_end_calc #(
   parameter int BASE_W  = 21,
   parameter int PAGE_W  = 11,
   parameter int GAP_W   = 11,
   parameter int LINES_W = 10
) (
   input  logic [BASE_W-1:0]  base,
   input  logic [PAGE_W-1:0]  page,
   input  logic [GAP_W-1:0]   gap,
   input  logic [LINES_W-1:0] lines,
   output logic [BASE_W-1:0]  end_base
);
   localparam int SPAN_W = ((PAGE_W > GAP_W) ? PAGE_W : GAP_W) + 1;
   localparam int PROD_W = SPAN_W + LINES_W + 1;

   logic [SPAN_W-1:0]  span;
   logic [LINES_W:0]   nlines;
   logic [PROD_W-1:0]  prod;

   // Closed form: each line consumes page + gap halfwords.
   always_comb begin
      span     = SPAN_W'(page) + SPAN_W'(gap);
      nlines   = {1'b0, lines} + (LINES_W+1)'(1);
      prod     = PROD_W'(span) * PROD_W'(nlines);
      end_base = base + BASE_W'(prod);
   end
endmodule

// File: rtl/fb_walker.sv
module fb_walker
   import fb_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  fb_geom_t            geom_in,
   input  logic                frame_start,
   input  logic                pix_req,
   output fb_geom_t            geom_q,
   output logic [BASE_W-1:0]   ptr,
   output logic                running,
   output logic                line_last,
   output logic                done
);
   logic [PAGE_W-1:0]  col;
   logic [LINES_W-1:0] row;

   assign line_last = running && (col == geom_q.page - PAGE_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         geom_q  <= '0;
         ptr     <= '0;
         col     <= '0;
         row     <= '0;
         running <= 1'b0;
         done    <= 1'b0;
      end else if (frame_start) begin
         geom_q  <= geom_in;
         ptr     <= geom_in.base;
         col     <= '0;
         row     <= '0;
         running <= (geom_in.page != '0);
         done    <= 1'b0;
      end else if (pix_req && running) begin
         if (line_last) begin
            ptr <= ptr + BASE_W'(geom_q.gap) + BASE_W'(1);
            col <= '0;
            if (row == geom_q.lines) begin
               running <= 1'b0;
               done    <= 1'b1;
            end else begin
               row <= row + LINES_W'(1);
            end
         end else begin
            ptr <= ptr + BASE_W'(1);
            col <= col + PAGE_W'(1);
         end
      end
   end

   // R3: plain step inside a line
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && running && !line_last && !frame_start)
      |=> ptr == $past(ptr) + BASE_W'(1));

   // R4: skip over the gap after the last halfword of a line
   p_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_req && running && line_last && !frame_start)
      |=> ptr == $past(ptr) + BASE_W'(geom_q.gap) + BASE_W'(1));

   // R3: idle pointer does not move
   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !frame_start) |=> $stable(ptr) && $stable(done));

   // R6: running and done are never both set
   p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(running && done));
endmodule

// File: rtl/fb_lane_swap.sv
module fb_lane_swap #(
   parameter int WORD_W = 32
) (
   input  logic              swap_bytes,
   input  logic              swap_halves,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);
   localparam int NWORDS = WORD_W / 32;

   if (WORD_W % 32 != 0) begin : g_bad_width
      $error("fb_lane_swap: WORD_W must be a multiple of 32");
   end

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      for (genvar h = 0; h < 2; h++) begin : g_half
         logic [15:0] src;
         assign src = swap_halves ? din[w*32 + (1-h)*16 +: 16]
                                  : din[w*32 + h*16 +: 16];
         assign dout[w*32 + h*16 +: 16] = swap_bytes ? {src[7:0], src[15:8]} : src;
      end
   end
endmodule

// File: rtl/fb_addr_gen.sv
module fb_addr_gen
   import fb_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [BANK_W-1:0]   cfg_bank,
   input  logic [BASE_W-1:0]   cfg_base,
   input  logic [PAGE_W-1:0]   cfg_page_width,
   input  logic [GAP_W-1:0]    cfg_offset,
   input  logic [LINES_W-1:0]  cfg_line_last,
   input  logic                swap_bytes,
   input  logic                swap_halves,
   input  logic                frame_start,
   input  logic                pix_req,
   output logic [BANK_W+BASE_W-1:0] fetch_addr,
   output logic                line_end,
   output logic                frame_end,
   input  logic [WORD_W-1:0]   rd_data_in,
   output logic [WORD_W-1:0]   rd_data_out
);
   localparam int ADDR_W = BANK_W + BASE_W;

   if (BASE_W < 2 || PAGE_W < 1 || LINES_W < 1) begin : g_bad_cfg
      $error("fb_addr_gen: field widths out of range");
   end

   fb_geom_t          geom_in, geom_q;
   logic [BASE_W-1:0] ptr, end_base;
   logic              running, line_last, done;

   assign geom_in = '{bank: cfg_bank, base: cfg_base, page: cfg_page_width,
                      gap: cfg_offset, lines: cfg_line_last};

   fb_walker u_walk (
      .clk(clk), .rst_n(rst_n), .geom_in(geom_in),
      .frame_start(frame_start), .pix_req(pix_req),
      .geom_q(geom_q), .ptr(ptr), .running(running),
      .line_last(line_last), .done(done)
   );

   fb_end_calc #(.BASE_W(BASE_W), .PAGE_W(PAGE_W), .GAP_W(GAP_W),
                 .LINES_W(LINES_W)) u_end (
      .base(geom_q.base), .page(geom_q.page), .gap(geom_q.gap),
      .lines(geom_q.lines), .end_base(end_base)
   );

   fb_lane_swap #(.WORD_W(WORD_W)) u_swap (
      .swap_bytes(swap_bytes), .swap_halves(swap_halves),
      .din(rd_data_in), .dout(rd_data_out)
   );

   assign fetch_addr = {geom_q.bank, ptr};
   assign line_end   = line_last;
   assign frame_end  = done;

   // R6: walked pointer lands on the closed-form end address
   p_end_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> fetch_addr[BASE_W-1:0] == end_base);

   // R7: bank field holds between frame starts
   p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(fetch_addr[ADDR_W-1:BASE_W]));

   // R2: a frame start reloads the address and clears completion
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (fetch_addr == $past({cfg_bank, cfg_base})) && !frame_end);

   // R5: line_end only while a frame runs
   p_line_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      line_end |-> !frame_end);
endmodule

// File: tb/fb_addr_gen_tb.sv
`timescale 1ns/1ps
module fb_addr_gen_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [6:0]  cfg_bank = 0;
   logic [20:0] cfg_base = 0;
   logic [10:0] cfg_page_width = 0;
   logic [10:0] cfg_offset = 0;
   logic [9:0]  cfg_line_last = 0;
   logic        swap_bytes = 0, swap_halves = 0;
   logic        frame_start = 0, pix_req = 0;
   logic [27:0] fetch_addr;
   logic        line_end, frame_end;
   logic [31:0] rd_data_in = 0, rd_data_out;

   int checks = 0, errors = 0;

   // model state
   int m_bank, m_base, m_pw, m_off, m_total, m_k;
   bit m_run, m_started;

   always #2.5 clk = ~clk;

   fb_addr_gen u_dut (.*);

   function automatic int exp_base(int k);
      int v;
      v = m_base + (k / m_pw) * (m_pw + m_off) + (k % m_pw);
      return v & 32'h1FFFFF;
   endfunction

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_state();
      int eb;
      bit le, fe;
      if (!m_started) begin
         check("R1 addr", fetch_addr, 0);
         check("R1 flags", {line_end, frame_end}, 0);
         return;
      end
      eb = (m_pw == 0) ? m_base : exp_base(m_k);
      le = m_run && (m_pw != 0) && (m_k < m_total) && ((m_k % m_pw) == m_pw - 1);
      fe = (m_pw != 0) && (m_k == m_total);
      check("R3/R4/R7 addr", fetch_addr, (longint'(m_bank) << 21) | eb);
      check("R5 line_end", line_end, le);
      check("R6/R8 frame_end", frame_end, fe);
   endtask

   task automatic step(bit fs, bit req);
      frame_start = fs;
      pix_req     = req;
      @(posedge clk);
      if (fs) begin
         m_started = 1;
         m_bank = cfg_bank; m_base = cfg_base; m_pw = cfg_page_width;
         m_off = cfg_offset; m_total = m_pw * (cfg_line_last + 1);
         m_k = 0; m_run = (m_pw != 0);
      end else if (req && m_run && m_k < m_total) begin
         m_k++;
      end
      if (m_k == m_total) m_run = 0;
      @(negedge clk);
      check_state();
   endtask

   task automatic set_cfg(int bank, int base, int pw, int off, int ll);
      cfg_bank = 7'(bank); cfg_base = 21'(base); cfg_page_width = 11'(pw);
      cfg_offset = 11'(off); cfg_line_last = 10'(ll);
   endtask

   task automatic run_frame(int bank, int base, int pw, int off, int ll, int extra);
      set_cfg(bank, base, pw, off, ll);
      step(1, 1);   // R2: request in the frame-start cycle is ignored
      // R2: scramble config mid-frame; it must have no effect
      set_cfg($urandom, $urandom, $urandom_range(1, 9), $urandom, $urandom_range(0, 4));
      while (m_run) step(0, ($urandom_range(0, 3) != 0));
      for (int i = 0; i < extra; i++) step(0, 1);   // R6: ignored after end
   endtask

   function automatic logic [31:0] exp_swap(logic [31:0] d, bit b, bit h);
      logic [31:0] r;
      r = h ? {d[15:0], d[31:16]} : d;
      if (b) r = {r[23:16], r[31:24], r[7:0], r[15:8]};
      return r;
   endfunction

   initial begin
      #5ms;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20231));
      m_started = 0; m_run = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_state();                       // R1 during reset
      rst_n = 1;
      step(0, 1);                          // R1/R3: request before any frame ignored

      // directed: single halfword lines, zero gap
      run_frame(3, 100, 1, 0, 3, 2);
      // directed: base near wrap with large gap, bank must hold (R7)
      run_frame(7'h55, 21'h1FFFFD, 3, 2047, 2, 2);
      // directed: maximum line width pieces small, large gap
      run_frame(1, 0, 5, 2047, 0, 1);
      // directed: zero page width (R8)
      set_cfg(9, 1234, 0, 5, 2);
      step(1, 0);
      repeat (4) step(0, 1);
      // frame start while a frame is mid-way (R2)
      set_cfg(2, 500, 4, 3, 3);
      step(1, 0);
      repeat (5) step(0, 1);
      set_cfg(4, 800, 2, 1, 1);
      step(1, 1);
      while (m_run) step(0, 1);
      // random frames
      for (int f = 0; f < 25; f++)
         run_frame($urandom, $urandom, $urandom_range(1, 8),
                   ($urandom_range(0, 1) ? $urandom_range(0, 3) : $urandom_range(0, 2047)),
                   $urandom_range(0, 5), $urandom_range(0, 3));

      // lane swap R9/R10
      for (int i = 0; i < 24; i++) begin
         rd_data_in  = (i < 4) ? 32'hA1B2C3D4 : $urandom;
         swap_bytes  = i[0];
         swap_halves = i[1];
         #1;
         check(swap_halves ? "R10 swap" : (swap_bytes ? "R9 swap" : "R10 pass"),
               rd_data_out, exp_swap(rd_data_in, swap_bytes, swap_halves));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule